// File: doc/BRIEF.md
# Tiler polygon-list size calculator

This unit works out how many bytes a tile-based renderer needs for its polygon list. It can size the header alone, or the header together with the body. Software or a control sequencer drives it with a framebuffer width and height, a 12-bit configuration word, a mode flag and a sizing select, then pulses `start_i`. When the result is ready the unit raises `done_o` for one cycle and presents the byte count on `size_o`.

There are two modes. In hierarchical mode the configuration word holds a level mask. Each enabled level is a square power-of-two tile size, and the unit visits one level per clock. For each enabled level it adds the per-tile byte cost times that level's tile count. The sum starts at a small prologue, and the final value is rounded up to a 512-byte multiple. In flat mode the configuration word holds two exponents that give a single rectangular tile. The unit finds the tile count, takes the byte cost, rounds it down to a 512-byte multiple and then adds a fixed 512 bytes.

Top module: `tiler_list_sizer`

## Requirements
- R1: The per-tile cost is 8 bytes when `full_i`=0 (header sizing) and 512 bytes when `full_i`=1 (header plus body sizing).
- R2: In hierarchical mode (`hier_i`=1) the raw sum is 64 plus, for every set bit b in `cfg_i[7:0]`, cost × ceil(W/T) × ceil(H/T) with T = 16·2^b.
- R3: In hierarchical mode `cfg_i[11:8]` has no effect on the result.
- R4: The hierarchical result is the raw sum rounded up to the next multiple of 512. An empty mask therefore gives 512.
- R5: In flat mode (`hier_i`=0) the tile width is 16·2^cfg_i[2:0] and the tile height is 16·2^cfg_i[8:6]. Bits [5:3] and [11:9] have no effect.
- R6: The flat result is 512 + floor(cost × ceil(W/w) × ceil(H/h) / 512) × 512.
- R7: Tile counts round up separately in each direction. A zero width or height gives zero tiles.
- R8: `done_o` is high in the 9th cycle after the clock edge that accepts `start_i` in hierarchical mode, and in the 2nd cycle after it in flat mode.
- R9: `done_o` lasts exactly one cycle. `size_o` changes only together with a `done_o` pulse and holds its value until the next one.
- R10: A `start_i` seen while a computation is in progress is ignored. The running result is not disturbed and no extra `done_o` pulse follows.
- R11: During reset `done_o` is 0 and `size_o` is 0.
- R12: `size_o` carries the low 32 bits of the exact result. Wider results wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a computation (accepted only when idle) |
| width_i | input | 16 | Framebuffer width in pixels |
| height_i | input | 16 | Framebuffer height in pixels |
| cfg_i | input | 12 | Level mask (hierarchical) or tile exponents (flat) |
| hier_i | input | 1 | 1 = hierarchical sizing, 0 = flat sizing |
| full_i | input | 1 | 1 = header plus body, 0 = header only |
| done_o | output | 1 | One-cycle result strobe |
| size_o | output | 32 | Computed byte count |

## Verification
A level counter that skips or repeats a step, or a wrong shift for the tile size, changes the sum by a whole level's bytes. That error is visible on `size_o` at the single `done_o` pulse, 9 or 2 cycles after start. A latch that reloads while the unit is busy would show as a result matching the second set of inputs rather than the first. A sequencer that fails to return to idle shows as a missing or repeated `done_o`. Random framebuffer sizes, masks and exponents are compared at every pulse against a bench model evaluated with 64-bit arithmetic, and the pulse cycle is counted on every run.

// File: rtl/tls_pkg.sv
package tls_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HIER = 2'd1,
        S_FLAT = 2'd2,
        S_FIN  = 2'd3
    } tls_state_t;
endpackage

// File: rtl/tls_tile_count.sv
module tls_tile_count #(
    parameter int DIM_W = 16,
    parameter int SH_W  = 4,
    localparam int CNT_W = 2 * (DIM_W + 1)
) (
    input  logic [DIM_W-1:0] w_i,
    input  logic [DIM_W-1:0] h_i,
    input  logic [SH_W-1:0]  shx_i,
    input  logic [SH_W-1:0]  shy_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [DIM_W:0] ONE = 1;

    logic [DIM_W:0] mx, my, cx, cy;

    always_comb begin
        mx = (ONE << shx_i) - ONE;
        my = (ONE << shy_i) - ONE;
        cx = ({1'b0, w_i} + mx) >> shx_i;
        cy = ({1'b0, h_i} + my) >> shy_i;
        count_o = CNT_W'(cx) * CNT_W'(cy);
    end

    // R7: a non-empty frame always yields at least one tile
    always_comb begin
        if (w_i != '0 && h_i != '0) begin
            p_count_nonzero_r7: assert (count_o != '0);
        end
    end
endmodule

// File: rtl/tls_align.sv
module tls_align #(
    parameter int VAL_W   = 40,
    parameter int ALIGN_SH = 9
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic             up_i,
    output logic [VAL_W-1:0] val_o
);
    localparam logic [VAL_W-1:0] ONE = 1;
    localparam logic [VAL_W-1:0] LOW = (ONE << ALIGN_SH) - ONE;

    logic [VAL_W-1:0] rounded_up, floored_plus;

    always_comb begin
        rounded_up   = (val_i + LOW) & ~LOW;
        floored_plus = (val_i & ~LOW) + (LOW + ONE);
        val_o        = up_i ? rounded_up : floored_plus;
    end
endmodule

// File: rtl/tiler_list_sizer.sv
module tiler_list_sizer #(
    parameter int DIM_W      = 16,
    parameter int SIZE_W     = 32,
    parameter int CFG_W      = 12,
    parameter int LEVELS     = 8,
    parameter int BASE_SH    = 4,
    parameter int EXP_W      = 3,
    parameter int WEXP_LSB   = 0,
    parameter int HEXP_LSB   = 6,
    parameter int PROLOGUE   = 64,
    parameter int HDR_SH     = 3,
    parameter int FULL_SH    = 9,
    parameter int ALIGN_SH   = 9,
    parameter int ACC_W      = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              hier_i,
    input  logic              full_i,
    output logic              done_o,
    output logic [SIZE_W-1:0] size_o
);
    import tls_pkg::*;

    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int SH_W  = $clog2(BASE_SH + LEVELS + (1 << EXP_W) + 1);
    localparam int CNT_W = 2 * (DIM_W + 1);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        tls_state_t        state;
        logic [LVL_W-1:0]  lvl;
        logic [ACC_W-1:0]  acc;
        logic [DIM_W-1:0]  w;
        logic [DIM_W-1:0]  h;
        logic [CFG_W-1:0]  cfg;
        logic              hier;
        logic              full;
        logic              done;
        logic [SIZE_W-1:0] size;
    } regs_t;

    regs_t r_d, r_q;

    logic [SH_W-1:0]  shx, shy;
    logic [CNT_W-1:0] tiles;
    logic [ACC_W-1:0] level_bytes;
    logic [ACC_W-1:0] aligned;

    always_comb begin
        if (r_q.hier) begin
            shx = SH_W'(BASE_SH) + SH_W'(r_q.lvl);
            shy = SH_W'(BASE_SH) + SH_W'(r_q.lvl);
        end else begin
            shx = SH_W'(BASE_SH) + SH_W'(r_q.cfg[WEXP_LSB +: EXP_W]);
            shy = SH_W'(BASE_SH) + SH_W'(r_q.cfg[HEXP_LSB +: EXP_W]);
        end
    end

    tls_tile_count #(.DIM_W(DIM_W), .SH_W(SH_W)) u_count (
        .w_i     (r_q.w),
        .h_i     (r_q.h),
        .shx_i   (shx),
        .shy_i   (shy),
        .count_o (tiles)
    );

    assign level_bytes = ACC_W'(tiles) << (r_q.full ? FULL_SH : HDR_SH);

    tls_align #(.VAL_W(ACC_W), .ALIGN_SH(ALIGN_SH)) u_align (
        .val_i (r_q.acc),
        .up_i  (r_q.hier),
        .val_o (aligned)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.w     = width_i;
                    r_d.h     = height_i;
                    r_d.cfg   = cfg_i;
                    r_d.hier  = hier_i;
                    r_d.full  = full_i;
                    r_d.lvl   = '0;
                    r_d.acc   = hier_i ? ACC_W'(PROLOGUE) : '0;
                    r_d.state = hier_i ? S_HIER : S_FLAT;
                end
            end
            S_HIER: begin
                if (r_q.cfg[r_q.lvl]) begin
                    r_d.acc = r_q.acc + level_bytes;
                end
                r_d.lvl = r_q.lvl + LVL_W'(1);
                if (r_q.lvl == LAST_LVL) begin
                    r_d.state = S_FIN;
                end
            end
            S_FLAT: begin
                r_d.acc   = level_bytes;
                r_d.state = S_FIN;
            end
            S_FIN: begin
                r_d.size  = aligned[SIZE_W-1:0];
                r_d.done  = 1'b1;
                r_d.state = S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;
    assign size_o = r_q.size;

    // R9: strobe lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: result only moves together with the strobe
    p_size_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(size_o));

    // R10: a request during a run leaves the latched operands alone
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != S_IDLE && start_i) |=>
            ($stable(r_q.cfg) && $stable(r_q.w) && $stable(r_q.h) && $stable(r_q.hier)));

    // R4 and R6: both modes end on a 512-byte boundary
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (size_o[ALIGN_SH-1:0] == '0));

    // R8: flat mode spends one cycle computing before finishing
    p_flat_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FLAT) |=> (r_q.state == S_FIN));

    // R8: the finishing cycle always raises the strobe
    p_fin_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FIN) |=> done_o);
endmodule

// File: tb/sim_tiler_list_sizer.sv
module sim_tiler_list_sizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] width_i = '0;
    logic [15:0] height_i = '0;
    logic [11:0] cfg_i = '0;
    logic        hier_i = 1'b0;
    logic        full_i = 1'b0;
    logic        done_o;
    logic [31:0] size_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tiler_list_sizer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .width_i(width_i), .height_i(height_i), .cfg_i(cfg_i),
        .hier_i(hier_i), .full_i(full_i),
        .done_o(done_o), .size_o(size_o)
    );

    function automatic longint tiles(longint w, longint h, int sx, int sy);
        longint cx = (w + (64'd1 << sx) - 1) >> sx;
        longint cy = (h + (64'd1 << sy) - 1) >> sy;
        return cx * cy;
    endfunction

    function automatic longint model(longint w, longint h, logic [11:0] c, bit hi, bit fu);
        longint cost = fu ? 512 : 8;
        longint acc;
        if (hi) begin
            acc = 64;
            for (int b = 0; b < 8; b++)
                if (c[b]) acc += cost * tiles(w, h, 4 + b, 4 + b);
            acc = ((acc + 511) / 512) * 512;
        end else begin
            acc = cost * tiles(w, h, 4 + int'(c[2:0]), 4 + int'(c[8:6]));
            acc = 512 + (acc / 512) * 512;
        end
        return acc & 64'hFFFF_FFFF;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] w, input logic [15:0] h, input logic [11:0] c,
                       input bit hi, input bit fu, input bit inject, input string tag);
        logic [31:0] sz;
        int lat;
        bit extra;
        @(negedge clk);
        width_i = w; height_i = h; cfg_i = c; hier_i = hi; full_i = fu; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 60) begin
            @(negedge clk);
            lat++;
            if (inject && lat == 1) begin
                width_i = ~w; height_i = h ^ 16'h00F3; cfg_i = ~c; hier_i = ~hi; full_i = ~fu;
                start_i = 1'b1;
            end
            if (inject && lat == 2) start_i = 1'b0;
        end
        sz = size_o;
        check({tag, " R8 latency"}, lat, hi ? 9 : 2);
        check({tag, " size R1 R2 R5 R6"}, sz, model(w, h, c, hi, fu));
        @(negedge clk);
        check({tag, " R9 pulse"}, done_o, 0);
        check({tag, " R9 hold"}, size_o, sz);
        if (inject) begin
            extra = 1'b0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            check({tag, " R10 no extra strobe"}, extra, 0);
            check({tag, " R10 result kept"}, size_o, sz);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check("R11 done in reset", done_o, 0);
        check("R11 size in reset", size_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(16'd1920, 16'd1080, 12'h0FF, 1, 0, 0, "R1 R2 hier header");
        run(16'd1920, 16'd1080, 12'h0FF, 1, 1, 0, "R1 R2 hier full");
        run(16'd800, 16'd600, 12'h000, 1, 1, 0, "R4 empty mask");
        check("R4 empty mask gives 512", model(800, 600, 12'h000, 1, 1), 512);
        run(16'd800, 16'd600, 12'hF00, 1, 1, 0, "R3 high bits only");
        run(16'd640, 16'd480, 12'hF05, 1, 0, 0, "R3 high bits set");
        run(16'd17, 16'd1, 12'h000, 0, 0, 0, "R6 flat round down");
        run(16'd33, 16'd16, 12'h000, 0, 1, 0, "R7 round up width");
        run(16'd1000, 16'd700, 12'hE3A, 0, 1, 0, "R5 ignored flat bits");
        run(16'd0, 16'd0, 12'h1C7, 0, 1, 0, "R7 zero frame");
        run(16'hFFFF, 16'hFFFF, 12'h0FF, 1, 1, 0, "R12 wrap hier");
        run(16'hFFFF, 16'hFFFF, 12'h000, 0, 1, 0, "R12 wrap flat");
        run(16'd1280, 16'd720, 12'h0F0, 1, 1, 1, "R10 busy hier");
        run(16'd1280, 16'd720, 12'h081, 0, 1, 1, "R10 busy flat");

        for (int i = 0; i < 60; i++) begin
            logic [15:0] rw = 16'($urandom);
            logic [15:0] rh = 16'($urandom);
            logic [11:0] rc = 12'($urandom);
            bit rhi = 1'($urandom);
            bit rfu = 1'($urandom);
            if (i % 3 == 0) begin
                rw = rw & 16'h0FFF;
                rh = rh & 16'h0FFF;
            end
            run(rw, rh, rc, rhi, rfu, (i % 10) == 4, "random R2 R6");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule